// File: doc/BRIEF.md
# Grouped Store-Load Overlap Detector

This block keeps a small table of the stores accepted so far in the current dispatch group. It answers, in the same cycle, whether a load now being presented would read bytes that one of those stores writes. Each access is described by three fields: a base identifier naming the pointer it goes through, a signed byte offset from that base, and an unsigned byte count. Two accesses can only collide when their base identifiers are the same. When they are, the signed offset ranges decide the result.

A scheduler writes each store into the table as it is placed in the group. It presents each load candidate for a check and raises the group-clear input when a new group starts. The table has a fixed number of slots per group. Stores that arrive after it is full are not tracked. A store written in a given cycle is visible to loads from the next cycle onward. Deriving the base identifiers and deciding what to do about a conflict are left to the surrounding logic.

Top module: `grp_overlap_det`

## Requirements
- R1: After reset the table is empty and no load reports a conflict.
- R2: A store presented with `st_vld` high is recorded at the next clock edge and is compared against loads from the following cycle on; a load in the same cycle as the store does not see that store.
- R3: At most DEPTH (default 4) stores are recorded per group; a store presented while the table is full is dropped, and a load matching only that store reports no conflict.
- R4: A load whose base and offset both equal a recorded entry's conflicts, whatever the two sizes are, including zero.
- R5: With equal bases and the store offset strictly below the load offset, there is a conflict exactly when store offset plus store size is greater than the load offset.
- R6: With equal bases and the store offset strictly above the load offset, there is a conflict exactly when load offset plus load size is greater than the store offset.
- R7: A load whose base differs from every recorded entry's reports no conflict, whatever its offsets are.
- R8: `conflict` is low whenever `ld_vld` is low.
- R9: A `grp_clr` pulse without a store leaves the table empty from the next cycle.
- R10: `grp_clr` and `st_vld` high in the same cycle leave exactly the new store recorded, as the only entry.
- R11: Offsets are two's-complement signed values of OFS_W bits (default 64) and sizes are unsigned. The offset-plus-size sums do not wrap, so ranges near the most positive or most negative offset compare correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_clr | input | 1 | Start of a new group: empties the table |
| st_vld | input | 1 | Record the store on the st_* fields |
| st_base | input | BASE_W | Store base identifier |
| st_ofs | input | OFS_W | Store signed byte offset |
| st_size | input | SIZE_W | Store byte count |
| ld_vld | input | 1 | A load is presented for checking |
| ld_base | input | BASE_W | Load base identifier |
| ld_ofs | input | OFS_W | Load signed byte offset |
| ld_size | input | SIZE_W | Load byte count |
| conflict | output | 1 | Load overlaps a recorded store (combinational) |

## Verification
Directed loads are placed one byte on each side of every range edge. This separates the strict from the non-strict comparison in both the below-store and above-store cases, and it separates the exact-match rule from the range rules through zero-size accesses. Offsets near the positive limit and below zero show whether the sums keep their carry and whether the comparison is signed. Filling the table and adding a fifth store, clearing with and without a simultaneous store, and loading in the same cycle as a store check the slot count and the write timing. A long stretch of random stores, loads and clears over a narrow range of bases and offsets is then compared each cycle against a queue-based model, so that multi-entry hits and partial fills are also covered.

// File: rtl/sld_pkg.sv
package sld_pkg;
   // Reason a single entry reports a hit against the presented load.
   typedef enum logic [1:0] {
      HIT_NONE  = 2'd0,
      HIT_EXACT = 2'd1,
      HIT_BELOW = 2'd2,
      HIT_ABOVE = 2'd3
   } hit_kind_e;
endpackage

// File: rtl/sld_store_table.sv
module sld_store_table #(
   parameter int BASE_W = 16,
   parameter int OFS_W  = 64,
   parameter int SIZE_W = 8,
   parameter int DEPTH  = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          grp_clr,
   input  logic                          st_vld,
   input  logic [BASE_W-1:0]             st_base,
   input  logic [OFS_W-1:0]              st_ofs,
   input  logic [SIZE_W-1:0]             st_size,
   output logic [DEPTH-1:0]              ent_vld,
   output logic [DEPTH-1:0][BASE_W-1:0]  ent_base,
   output logic [DEPTH-1:0][OFS_W-1:0]   ent_ofs,
   output logic [DEPTH-1:0][SIZE_W-1:0]  ent_size
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   logic [CNT_W-1:0] cnt_q;
   logic             wr_en;
   logic [CNT_W-1:0] wr_idx;

   assign wr_en  = st_vld && (grp_clr || (cnt_q < FULL));
   assign wr_idx = grp_clr ? '0 : cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (wr_en) begin
         cnt_q <= grp_clr ? CNT_W'(1) : cnt_q + CNT_W'(1);
      end else if (grp_clr) begin
         cnt_q <= '0;
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      assign ent_vld[i] = (cnt_q > CNT_W'(i));
      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == CNT_W'(i))) begin
            ent_base[i] <= st_base;
            ent_ofs[i]  <= st_ofs;
            ent_size[i] <= st_size;
         end
      end
   end

   // R3
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL);
   // R3
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == FULL && st_vld && !grp_clr) |=> (cnt_q == FULL));
   // R2
   store_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_vld && !grp_clr && cnt_q < FULL) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
   // R9
   clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_clr && !st_vld) |=> (ent_vld == '0));
   // R10
   clr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_clr && st_vld) |=> (ent_vld == DEPTH'(1)));
endmodule

// File: rtl/sld_range_cmp.sv
module sld_range_cmp
   import sld_pkg::*;
#(
   parameter int BASE_W = 16,
   parameter int OFS_W  = 64,
   parameter int SIZE_W = 8
) (
   input  logic              e_vld,
   input  logic [BASE_W-1:0] e_base,
   input  logic [OFS_W-1:0]  e_ofs,
   input  logic [SIZE_W-1:0] e_size,
   input  logic [BASE_W-1:0] l_base,
   input  logic [OFS_W-1:0]  l_ofs,
   input  logic [SIZE_W-1:0] l_size,
   output hit_kind_e         kind
);
   // Two guard bits: one for the sign extension, one for the carry.
   localparam int SUM_W = OFS_W + 2;

   logic signed [SUM_W-1:0] s_lo, s_hi, l_lo, l_hi;

   assign s_lo = SUM_W'($signed(e_ofs));
   assign l_lo = SUM_W'($signed(l_ofs));
   assign s_hi = s_lo + $signed(SUM_W'(e_size));
   assign l_hi = l_lo + $signed(SUM_W'(l_size));

   always_comb begin
      kind = HIT_NONE;
      if (e_vld && (e_base == l_base)) begin
         if (s_lo == l_lo)     kind = HIT_EXACT;
         else if (s_lo < l_lo) kind = (s_hi > l_lo) ? HIT_BELOW : HIT_NONE;
         else                  kind = (l_hi > s_lo) ? HIT_ABOVE : HIT_NONE;
      end
   end
endmodule

// File: rtl/grp_overlap_det.sv
module grp_overlap_det
   import sld_pkg::*;
#(
   parameter int BASE_W = 16,
   parameter int OFS_W  = 64,
   parameter int SIZE_W = 8,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              grp_clr,
   input  logic              st_vld,
   input  logic [BASE_W-1:0] st_base,
   input  logic [OFS_W-1:0]  st_ofs,
   input  logic [SIZE_W-1:0] st_size,
   input  logic              ld_vld,
   input  logic [BASE_W-1:0] ld_base,
   input  logic [OFS_W-1:0]  ld_ofs,
   input  logic [SIZE_W-1:0] ld_size,
   output logic              conflict
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("grp_overlap_det: DEPTH must be at least 1");
   end
   if (BASE_W < 1) begin : g_bad_base
      $error("grp_overlap_det: BASE_W must be at least 1");
   end
   if (SIZE_W >= OFS_W) begin : g_bad_size
      $error("grp_overlap_det: SIZE_W must be narrower than OFS_W");
   end

   logic [DEPTH-1:0]             ent_vld;
   logic [DEPTH-1:0][BASE_W-1:0] ent_base;
   logic [DEPTH-1:0][OFS_W-1:0]  ent_ofs;
   logic [DEPTH-1:0][SIZE_W-1:0] ent_size;
   logic [DEPTH-1:0]             hit_vec;

   sld_store_table #(
      .BASE_W(BASE_W), .OFS_W(OFS_W), .SIZE_W(SIZE_W), .DEPTH(DEPTH)
   ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .grp_clr  (grp_clr),
      .st_vld   (st_vld),
      .st_base  (st_base),
      .st_ofs   (st_ofs),
      .st_size  (st_size),
      .ent_vld  (ent_vld),
      .ent_base (ent_base),
      .ent_ofs  (ent_ofs),
      .ent_size (ent_size)
   );

   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      hit_kind_e kind;
      sld_range_cmp #(
         .BASE_W(BASE_W), .OFS_W(OFS_W), .SIZE_W(SIZE_W)
      ) u_cmp (
         .e_vld  (ent_vld[i]),
         .e_base (ent_base[i]),
         .e_ofs  (ent_ofs[i]),
         .e_size (ent_size[i]),
         .l_base (ld_base),
         .l_ofs  (ld_ofs),
         .l_size (ld_size),
         .kind   (kind)
      );
      assign hit_vec[i] = (kind != HIT_NONE);
   end

   assign conflict = ld_vld && (|hit_vec);

   // R8
   no_ld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_vld |-> !conflict);
   // R1
   empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_vld == '0) |-> !conflict);
   // R1
   reset_empty_chk: assert property (@(posedge clk)
      $past(!rst_n) |-> (ent_vld == '0));
endmodule

// File: tb/tb_grp_overlap_det.sv
module tb_grp_overlap_det;
   localparam int CLK_PERIOD = 10;
   localparam int BASE_W = 16;
   localparam int OFS_W  = 64;
   localparam int SIZE_W = 8;
   localparam int DEPTH  = 4;

   typedef logic signed [127:0] wide_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic grp_clr = 1'b0, st_vld = 1'b0, ld_vld = 1'b0;
   logic [BASE_W-1:0] st_base = '0, ld_base = '0;
   logic [OFS_W-1:0]  st_ofs = '0, ld_ofs = '0;
   logic [SIZE_W-1:0] st_size = '0, ld_size = '0;
   logic conflict;

   int n_cmp = 0;
   int n_bad = 0;

   // model table
   int     m_base[$];
   longint m_ofs[$];
   int     m_size[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   grp_overlap_det #(
      .BASE_W(BASE_W), .OFS_W(OFS_W), .SIZE_W(SIZE_W), .DEPTH(DEPTH)
   ) dut (
      .clk(clk), .rst_n(rst_n), .grp_clr(grp_clr),
      .st_vld(st_vld), .st_base(st_base), .st_ofs(st_ofs), .st_size(st_size),
      .ld_vld(ld_vld), .ld_base(ld_base), .ld_ofs(ld_ofs), .ld_size(ld_size),
      .conflict(conflict)
   );

   function automatic bit model_hit(int lb, longint lo, int ls);
      bit r = 1'b0;
      for (int k = 0; k < m_base.size(); k++) begin
         wide_t so = wide_t'(m_ofs[k]);
         wide_t ld = wide_t'(lo);
         if (m_base[k] != lb) continue;
         if (so == ld) r = 1'b1;                              // R4
         else if (so < ld && so + wide_t'(m_size[k]) > ld) r = 1'b1;   // R5
         else if (so > ld && ld + wide_t'(ls) > so) r = 1'b1;          // R6
      end
      return r;
   endfunction

   // One cycle: drive, compare away from the edge, then advance the model.
   task automatic step(string tag, bit clr, bit sv, int sb, longint so, int ss,
                       bit lv, int lb, longint lo, int ls);
      bit exp;
      @(negedge clk);
      grp_clr = clr; st_vld = sv;
      st_base = BASE_W'(sb); st_ofs = OFS_W'(so); st_size = SIZE_W'(ss);
      ld_vld = lv; ld_base = BASE_W'(lb); ld_ofs = OFS_W'(lo); ld_size = SIZE_W'(ls);
      #1;
      exp = lv && rst_n && model_hit(lb, lo, ls);   // R8: no load, no conflict
      n_cmp++;
      if (conflict !== exp) begin
         n_bad++;
         $display("FAIL %s: conflict=%b expected=%b (ld base=%0d ofs=%0d size=%0d)",
                  tag, conflict, exp, lb, lo, ls);
      end
      if (rst_n) begin
         if (clr) begin
            m_base.delete(); m_ofs.delete(); m_size.delete();
         end
         if (sv && m_base.size() < DEPTH) begin
            m_base.push_back(sb); m_ofs.push_back(so); m_size.push_back(ss);
         end
      end
   endtask

   task automatic st(string tag, int b, longint o, int s);
      step(tag, 0, 1, b, o, s, 0, 0, 0, 0);
   endtask
   task automatic ld(string tag, int b, longint o, int s);
      step(tag, 0, 0, 0, 0, 0, 1, b, o, s);
   endtask
   task automatic clr(string tag);
      step(tag, 1, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: empty after reset
      ld("R1", 0, 0, 8);
      ld("R1", 5, 100, 255);
      // R2: same-cycle store is invisible, next cycle visible
      step("R2", 0, 1, 3, 100, 8, 1, 3, 100, 8);
      ld("R2", 3, 100, 8);
      // R8: load valid low masks a match
      step("R8", 0, 0, 0, 0, 0, 0, 3, 100, 8);
      // R5: store [100,+8) vs loads above it
      ld("R5", 3, 107, 1);
      ld("R5", 3, 108, 4);
      ld("R5", 3, 101, 0);
      // R6: load below store at 100
      ld("R6", 3, 90, 10);
      ld("R6", 3, 90, 11);
      ld("R6", 3, 99, 1);
      // R4: exact match with zero sizes
      clr("R9");
      ld("R9", 3, 100, 8);
      st("R4", 7, 40, 0);
      ld("R4", 7, 40, 0);
      ld("R4", 7, 39, 1);
      // R7: other base
      ld("R7", 8, 40, 0);
      ld("R7", 6, 38, 10);
      // R3: fill, overflow store dropped
      st("R3", 7, 200, 4);
      st("R3", 7, 300, 4);
      st("R3", 7, 400, 4);
      st("R3", 7, 500, 4);
      ld("R3", 7, 500, 4);
      ld("R3", 7, 403, 1);
      // R10: clear together with a store
      step("R10", 1, 1, 9, 1000, 16, 0, 0, 0, 0);
      ld("R10", 9, 1015, 1);
      ld("R10", 7, 200, 4);
      ld("R10", 7, 40, 0);
      // R11: sums near the positive limit must not wrap
      clr("R11");
      st("R11", 2, 64'sh7FFF_FFFF_FFFF_FF00, 255);
      ld("R11", 2, 64'sh7FFF_FFFF_FFFF_FFFE, 1);
      ld("R11", 2, 64'sh7FFF_FFFF_FFFF_FFFF, 1);
      ld("R11", 2, 64'sh7FFF_FFFF_FFFF_FEF0, 255);
      ld("R11", 2, -64'sh8000_0000_0000_0000, 255);
      st("R11", 4, -8, 8);
      ld("R11", 4, -1, 1);
      ld("R11", 4, 0, 1);
      ld("R11", 4, -20, 12);
      ld("R11", 4, -20, 13);
      // random mix, compared every cycle
      for (int n = 0; n < 3000; n++) begin
         bit c = ($urandom_range(0, 15) == 0);
         bit s = ($urandom_range(0, 2) == 0);
         step("R5/R6 random", c, s,
              $urandom_range(0, 2), longint'($urandom_range(0, 40)) - 20,
              $urandom_range(0, 12),
              $urandom_range(0, 3) != 0,
              $urandom_range(0, 2), longint'($urandom_range(0, 40)) - 20,
              $urandom_range(0, 12));
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule